// File: doc/BRIEF.md
# Presettable Binary Up/Down Counter

A small binary counter that steps by one on each rising clock edge, either upward or downward as chosen by a single direction input. It counts only while the active-low enable is asserted. An active-low load input places a data word on the count output at once, with no clock edge needed, and overrides counting for as long as it is held low. When load is released, counting resumes from the loaded value at the next enabled rising edge. The count is undefined from power-up until the first load.

A direction-aware terminal-count flag marks the last state before wrap-around. It marks the all-ones state when counting up and the all-zeros state when counting down. Two cascade outputs are built on it. The first is an active-low ripple pulse that copies the low phase of the clock while the stage is enabled and at terminal count, for chains that clock each later stage from the one before. The second is a clock-free carry, terminal count qualified by enable, for chains that share one clock and gate the enables of the later stages.

Top module: `updown_preset_counter`

## Requirements
- R1: While load_n is low, q equals d within the same clock phase, with no clock edge, and q follows any change of d.
- R2: A low load_n overrides counting: with ce_n low and clock edges arriving, q stays equal to d.
- R3: With load_n high and ce_n high, q keeps its value across rising edges, whatever dir does.
- R4: With load_n high, ce_n low and dir low (count up), each rising edge adds one to q, and the all-ones value (15 at WIDTH 4) wraps to 0.
- R5: With load_n high, ce_n low and dir high (count down), each rising edge subtracts one from q, and 0 wraps to the all-ones value.
- R6: tc is high exactly when q is all ones with dir low, or q is 0 with dir high. It does not depend on ce_n, so a change of dir alone can clear it.
- R7: rc_n is low only while tc is high, ce_n is low and clk is low. It is high in every clock-high phase.
- R8: A high ce_n holds rc_n high even at terminal count.
- R9: carry equals tc AND NOT ce_n in both clock phases.
- R10: After load_n rises, the first enabled rising edge steps from the loaded value.
- R11: Preset to 12 and counting up gives 13, 14, 15, 0, 1, 2. Enable off then holds 2. Counting down then gives 1, 0, 15, 14, 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| load_n | input | 1 | Asynchronous parallel load, active low |
| ce_n | input | 1 | Count enable, active low |
| dir | input | 1 | Direction: 0 counts up, 1 counts down |
| d | input | WIDTH | Parallel load data |
| q | output | WIDTH | Count value |
| tc | output | 1 | Terminal count for the selected direction |
| rc_n | output | 1 | Gated ripple pulse, active low |
| carry | output | 1 | Clock-free cascade carry: tc with enable |

## Verification
The assertions assume that ce_n rises and dir changes only while clk is high, and that all inputs are settled before each rising edge. They also assume that d is held steady from the last rising edge inside a load window until load_n is released. Clocked checks are disabled while load_n is low, so nothing is judged on the undefined power-up count. The stimulus changes every input one nanosecond after a rising edge, which falls in the high phase. It changes d during a load window only where a clock edge follows before release, and it starts with a load of zero.

// File: rtl/udc_pkg.sv
package udc_pkg;
   typedef enum logic {
      UDC_UP   = 1'b0,
      UDC_DOWN = 1'b1
   } udc_dir_e;
endpackage

// File: rtl/udc_next.sv
module udc_next
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  udc_dir_e         dir_sel,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   always_comb begin
      if (dir_sel == UDC_DOWN) nxt = cur - STEP;
      else                     nxt = cur + STEP;
   end
endmodule

// File: rtl/udc_term.sv
module udc_term
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] val,
   input  udc_dir_e         dir_sel,
   output logic             tc
);
   logic [WIDTH:0] ones_run;
   logic [WIDTH:0] zeros_run;

   assign ones_run[0]  = 1'b1;
   assign zeros_run[0] = 1'b1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_chain
      assign ones_run[i+1]  = ones_run[i]  &  val[i];
      assign zeros_run[i+1] = zeros_run[i] & ~val[i];
   end

   assign tc = (dir_sel == UDC_DOWN) ? zeros_run[WIDTH] : ones_run[WIDTH];
endmodule

// File: rtl/udc_ripple.sv
module udc_ripple (
   input  logic clk,
   input  logic tc,
   input  logic ce_n,
   output logic carry,
   output logic rc_n
);
   assign carry = tc & ~ce_n;
   assign rc_n  = ~(carry & ~clk);
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             ce_n,
   input  logic             dir,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             tc,
   output logic             rc_n,
   output logic             carry
);
   localparam logic [WIDTH-1:0] CNT_MAX = '1;
   localparam logic [WIDTH-1:0] CNT_MIN = '0;

   if (WIDTH < 2) begin : g_bad_width
      $error("updown_preset_counter: WIDTH must be at least 2");
   end

   udc_dir_e         dir_sel;
   logic [WIDTH-1:0] state;
   logic [WIDTH-1:0] state_nxt;

   assign dir_sel = udc_dir_e'(dir);

   udc_next #(.WIDTH(WIDTH)) i_next (
      .cur     (state),
      .dir_sel (dir_sel),
      .nxt     (state_nxt)
   );

   // Asynchronous load branch; a held-low load also re-captures d on each edge.
   always_ff @(posedge clk or negedge load_n) begin
      if (!load_n)    state <= d;
      else if (!ce_n) state <= state_nxt;
   end

   // Output shows d directly while load is held, so later changes of d pass through.
   assign q = load_n ? state : d;

   udc_term #(.WIDTH(WIDTH)) i_term (
      .val     (q),
      .dir_sel (dir_sel),
      .tc      (tc)
   );

   udc_ripple i_ripple (
      .clk   (clk),
      .tc    (tc),
      .ce_n  (ce_n),
      .carry (carry),
      .rc_n  (rc_n)
   );

   // R3: disabled count holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!load_n)
      ce_n |=> q == $past(q));

   // R4: up step
   a_r4_count_up: assert property (@(posedge clk) disable iff (!load_n)
      (!ce_n && !dir) |=> q == WIDTH'($past(q) + 1'b1));

   // R5: down step
   a_r5_count_down: assert property (@(posedge clk) disable iff (!load_n)
      (!ce_n && dir) |=> q == WIDTH'($past(q) - 1'b1));

   // R6: terminal count marks the state that wraps next
   a_r6_tc_up_wrap: assert property (@(posedge clk) disable iff (!load_n)
      (!ce_n && !dir && tc) |=> q == CNT_MIN);

   a_r6_tc_down_wrap: assert property (@(posedge clk) disable iff (!load_n)
      (!ce_n && dir && tc) |=> q == CNT_MAX);

   // R7: ripple pulse low in the low phase at enabled terminal count
   a_r7_ripple_low: assert property (@(posedge clk) disable iff (!load_n)
      (tc && !ce_n) |-> !rc_n);

   // R7: ripple pulse high throughout the high phase
   a_r7_ripple_high_phase: assert property (@(negedge clk) disable iff (!load_n)
      rc_n);

   // R8: disabled stage sends no ripple pulse
   a_r8_ce_blocks_ripple: assert property (@(posedge clk) disable iff (!load_n)
      ce_n |-> rc_n);
endmodule

// File: tb/test_updown_preset_counter.sv
module test_updown_preset_counter;
   localparam int W    = 4;
   localparam int MAXV = 15;

   logic         clk    = 1'b0;
   logic         load_n = 1'b0;
   logic         ce_n   = 1'b1;
   logic         dir    = 1'b0;
   logic [W-1:0] d      = '0;
   logic [W-1:0] q;
   logic         tc;
   logic         rc_n;
   logic         carry;

   int n_chk  = 0;
   int n_fail = 0;
   int m      = 0;
   bit done   = 1'b0;

   updown_preset_counter #(.WIDTH(W)) i_updown_preset_counter (
      .clk    (clk),
      .load_n (load_n),
      .ce_n   (ce_n),
      .dir    (dir),
      .d      (d),
      .q      (q),
      .tc     (tc),
      .rc_n   (rc_n),
      .carry  (carry)
   );

   always #4 clk = ~clk;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_tc(int v, logic dr);
      if (dr) return (v == 0) ? 1 : 0;
      return (v == MAXV) ? 1 : 0;
   endfunction

   // One clock cycle: model the edge, apply new inputs, check both phases.
   task automatic cycle(logic ld, logic ce, logic dr, logic [W-1:0] dv);
      int t;
      @(posedge clk);
      if (!load_n)    m = int'(d);
      else if (!ce_n) m = dir ? (m + MAXV) % (MAXV + 1) : (m + 1) % (MAXV + 1);
      #1;
      load_n = ld; ce_n = ce; dir = dr; d = dv;
      if (!ld) m = int'(dv);
      #1;
      t = exp_tc(m, dr);
      if (!ld)     chk("R2 load wins", int'(q), m);
      else if (ce) chk("R3 hold", int'(q), m);
      else if (dr) chk("R5 down count", int'(q), m);
      else         chk("R4 up count", int'(q), m);
      chk("R6 tc", int'(tc), t);
      chk("R7 rc_n high phase", int'(rc_n), 1);
      chk("R9 carry high phase", int'(carry), (t == 1 && !ce) ? 1 : 0);
      @(negedge clk);
      #1;
      if (ce) chk("R8 rc_n disabled", int'(rc_n), 1);
      else    chk("R7 rc_n low phase", int'(rc_n), (t == 1) ? 0 : 1);
      chk("R9 carry low phase", int'(carry), (t == 1 && !ce) ? 1 : 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int seq_ce  [13] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1};
      int seq_dir [13] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
      int seq_q   [13] = '{13, 14, 15, 0, 1, 2, 2, 2, 1, 0, 15, 14, 13};

      // reset state: load of zero
      cycle(1'b0, 1'b1, 1'b0, 4'd0);
      cycle(1'b0, 1'b0, 1'b0, 4'd0);
      chk("R2 reset load", int'(q), 0);

      // R1: asynchronous load between edges
      cycle(1'b1, 1'b1, 1'b0, 4'd0);
      @(negedge clk);
      #1;
      d = 4'd9; load_n = 1'b0;
      #1;
      chk("R1 async load", int'(q), 9);
      d = 4'd5;
      #1;
      chk("R1 follows d", int'(q), 5);
      m = 5;
      cycle(1'b0, 1'b1, 1'b0, 4'd5);
      cycle(1'b1, 1'b0, 1'b0, 4'd5);
      chk("R10 released value", int'(q), 5);
      cycle(1'b1, 1'b1, 1'b0, 4'd0);
      chk("R10 resume step", int'(q), 6);

      // R6: dir change alone drops tc; ce_n has no effect on tc
      cycle(1'b0, 1'b1, 1'b0, 4'd15);
      cycle(1'b1, 1'b1, 1'b0, 4'd15);
      chk("R6 tc up at 15 with ce_n high", int'(tc), 1);
      cycle(1'b1, 1'b1, 1'b1, 4'd15);
      chk("R6 tc cleared by dir", int'(tc), 0);

      // R11: preset 12, count up, hold, count down
      cycle(1'b0, 1'b1, 1'b0, 4'd12);
      cycle(1'b1, 1'b0, 1'b0, 4'd12);
      for (int i = 0; i < 13; i++) begin
         cycle(1'b1, seq_ce[i][0], seq_dir[i][0], 4'd0);
         chk("R11 sequence", int'(q), seq_q[i]);
      end

      // random mixes of load, enable and direction
      for (int i = 0; i < 600; i++) begin
         cycle(($urandom % 10) != 0, ($urandom % 3) == 0, $urandom % 2 == 1, W'($urandom));
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule